// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects up to forty external event lines and turns selected transitions on them into interrupt requests for a downstream interrupt controller. The lines are split into two banks of registers: lines 0 to 31 live in the first bank and lines 32 to 39 in the second. Every line that has trigger logic carries six pieces of state: an interrupt enable, an event enable, a rising-edge select, a falling-edge select, a software trigger bit and a pending flag. Some lines are direct lines. They are wired through elsewhere in the chip, so their trigger, software and pending bits do not exist here.

External inputs pass through a two-flop synchronizer. An edge is found by comparing the newest synchronized sample with the one before it. When an enabled line sees a selected edge, or software raises its trigger bit from 0 to 1, the pending flag is set. In that same clock edge the line's output gives a single-cycle pulse, which the downstream controller latches. Software clears a pending flag by writing 1 to it, and that write also clears the line's software trigger bit. Registers are reached over a simple 32-bit bus: a write is captured on the rising clock edge and reads are combinational.

Top module: `ext_line_ctrl`

## Requirements
- R1: After reset every register reads 0x00000000 and no `irq_pulse` bit is high. Register index (address bits 4:2) is 0 interrupt enable, 1 event enable, 2 rising select, 3 falling select, 4 software trigger and 5 pending. Address bit 5 selects the bank (0x00-0x14 for the first bank, 0x20-0x34 for the second).
- R2: The interrupt-enable and event-enable registers keep all 32 written bits in the first bank and only bits 7:0 in the second bank. All other bits read as zero.
- R3: The rising and falling select registers keep only the bits in 0x007DFFFF (first bank) and 0x00000078 (second bank). All other bits ignore writes and read as zero.
- R4: Outside those same trigger masks (first bank bits 17 and 23-31, second bank bits 0-2, 7 and above), the software trigger and pending registers ignore writes and read as zero, and an input edge on such a line never sets a pending bit.
- R5: Writing a software trigger bit from 0 to 1 while that line is enabled stores the bit, sets the pending bit and pulses `irq_pulse`, all on the capturing clock edge. Software trigger bits otherwise take the written value.
- R6: A software trigger written while the line is disabled reads back as 1 but leaves pending clear. Enabling the line afterwards does not set pending.
- R7: Writing 1 to a pending bit clears it and the matching software trigger bit. Writing 0 changes nothing.
- R8: An input change sets pending on the third rising clock edge after it, only when the line is enabled and the edge type is selected (rising only, falling only, both). With neither select set, no edge is latched.
- R9: An edge that arrives while the line is disabled is not remembered. Enabling the line afterwards leaves pending clear.
- R10: `irq_pulse` for a line is high for exactly one cycle, on the edge where its pending bit goes from 0 to 1. A new trigger on an already pending line gives no pulse.
- R11: When a hardware edge and a pending-clear write hit the same line on the same clock edge, the pending bit stays set. The software trigger bit is still cleared.
- R12: Misaligned addresses, register indices 6 and 7, and banks that do not exist read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, captured on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| line_in | input | 40 | Asynchronous external event lines |
| irq_pulse | output | 40 | One-cycle interrupt request per line |

## Verification
Results arrive at different times. A bus write, and any pending bit or pulse it causes, appears on the edge that captures it. Read data follows the address with no clock at all. An input change needs three rising edges before its pending bit and pulse appear. The bench drives inputs on falling edges, reads registers a little after a falling edge, and counts pulses at falling edges. It checks pulse timing directly just after the relevant rising edge: at the edge that captures a software write, and at the second and third edges after an input change. Its reference model applies each input change only once three rising edges have gone by.

// File: rtl/eil_pkg.sv
`timescale 1ns/1ps
package eil_pkg;

  // Register index within a bank, taken from address bits 4:2.
  typedef enum logic [2:0] {
    RG_INTEN  = 3'd0,
    RG_EVTEN  = 3'd1,
    RG_RISE   = 3'd2,
    RG_FALL   = 3'd3,
    RG_SWTRIG = 3'd4,
    RG_PEND   = 3'd5
  } reg_sel_e;

  localparam int unsigned BANK_W = 32;

  // Default writable masks, first bank in the low word.
  localparam logic [63:0] DEF_EN_MASKS   = 64'h0000_00FF_FFFF_FFFF;
  localparam logic [63:0] DEF_TRIG_MASKS = 64'h0000_0078_007D_FFFF;

endpackage

// File: rtl/eil_sync.sv
`timescale 1ns/1ps
module eil_sync #(
  parameter int N = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] meta_q, cur_q, prev_q;

  // History keeps moving whatever the enables say: a masked edge is consumed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign rise = cur_q & ~prev_q;
  assign fall = ~cur_q & prev_q;

endmodule

// File: rtl/eil_bank.sv
`timescale 1ns/1ps
module eil_bank import eil_pkg::*; #(
  parameter int         W         = 32,
  parameter logic [W-1:0] EN_MASK   = '1,
  parameter logic [W-1:0] TRIG_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     reg_sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic [W-1:0] rdata,
  output logic [W-1:0] irq
);

  // Bits that go 0 -> 1 in a software write on enabled lines.
  function automatic logic [W-1:0] sw_fire(input logic [W-1:0] new_v,
                                           input logic [W-1:0] old_v,
                                           input logic [W-1:0] en_v);
    return new_v & ~old_v & en_v;
  endfunction

  // Enabled lines whose detected edge matches a selected polarity.
  function automatic logic [W-1:0] edge_hit(input logic [W-1:0] en_v,
                                            input logic [W-1:0] rsel,
                                            input logic [W-1:0] fsel,
                                            input logic [W-1:0] r_v,
                                            input logic [W-1:0] f_v);
    return en_v & ((rsel & r_v) | (fsel & f_v));
  endfunction

  logic [W-1:0] en_q, ev_q, rsel_q, fsel_q, sw_q, pend_q, irq_q;
  logic         wr_en_reg, wr_ev_reg, wr_rsel, wr_fsel, wr_sw, wr_pend;
  logic [W-1:0] sw_new, sw_set, hw_set, set_req, clr_req;

  assign wr_en_reg = wr_en && (reg_sel == RG_INTEN);
  assign wr_ev_reg = wr_en && (reg_sel == RG_EVTEN);
  assign wr_rsel   = wr_en && (reg_sel == RG_RISE);
  assign wr_fsel   = wr_en && (reg_sel == RG_FALL);
  assign wr_sw     = wr_en && (reg_sel == RG_SWTRIG);
  assign wr_pend   = wr_en && (reg_sel == RG_PEND);

  assign sw_new  = wdata & TRIG_MASK;
  assign sw_set  = wr_sw ? sw_fire(sw_new, sw_q, en_q) : '0;
  assign hw_set  = edge_hit(en_q, rsel_q, fsel_q, rise, fall);
  assign set_req = sw_set | hw_set;
  assign clr_req = wr_pend ? (wdata & TRIG_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      ev_q   <= '0;
      rsel_q <= '0;
      fsel_q <= '0;
      sw_q   <= '0;
      pend_q <= '0;
      irq_q  <= '0;
    end else begin
      if (wr_en_reg) en_q   <= wdata & EN_MASK;
      if (wr_ev_reg) ev_q   <= wdata & EN_MASK;
      if (wr_rsel)   rsel_q <= wdata & TRIG_MASK;
      if (wr_fsel)   fsel_q <= wdata & TRIG_MASK;
      if (wr_sw)     sw_q   <= sw_new;
      else           sw_q   <= sw_q & ~clr_req;
      // A new set outranks a clear on the same edge.
      pend_q <= (pend_q & ~clr_req) | set_req;
      irq_q  <= set_req & ~pend_q;
    end
  end

  always_comb begin
    unique case (reg_sel)
      RG_INTEN:  rdata = en_q;
      RG_EVTEN:  rdata = ev_q;
      RG_RISE:   rdata = rsel_q;
      RG_FALL:   rdata = fsel_q;
      RG_SWTRIG: rdata = sw_q;
      RG_PEND:   rdata = pend_q;
      default:   rdata = '0;
    endcase
  end

  assign irq = irq_q;

  // R10
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_q) |=> ((irq_q & $past(irq_q)) == '0));

  // R10
  irq_marks_new_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_q) |-> ((irq_q & ~pend_q) == '0));

  // R9
  pend_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  // R7
  pend_clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_req) |=> ((pend_q & $past(clr_req & ~set_req)) == '0));

  // R7
  swtrig_follows_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_req) |=> ((sw_q & $past(clr_req)) == '0));

  // R11
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_req & clr_req)) |=> ((~pend_q & $past(set_req & clr_req)) == '0));

endmodule

// File: rtl/ext_line_ctrl.sv
`timescale 1ns/1ps
module ext_line_ctrl import eil_pkg::*; #(
  parameter int NUM_LINES = 40,
  parameter int AW        = 8,
  parameter logic [((NUM_LINES+31)/32)*32-1:0] EN_MASKS   = DEF_EN_MASKS,
  parameter logic [((NUM_LINES+31)/32)*32-1:0] TRIG_MASKS = DEF_TRIG_MASKS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_LINES-1:0] irq_pulse
);

  localparam int NB = (NUM_LINES + 31) / 32;

  logic [NUM_LINES-1:0] rise_v, fall_v;
  logic [AW-6:0]        bank_idx;
  reg_sel_e             reg_idx;
  logic                 aligned;
  logic [31:0]          rd_bank [NB];

  assign bank_idx = bus_addr[AW-1:5];
  assign reg_idx  = reg_sel_e'(bus_addr[4:2]);
  assign aligned  = (bus_addr[1:0] == 2'b00);

  eil_sync #(.N(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (line_in),
    .rise     (rise_v),
    .fall     (fall_v)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int BW = ((NUM_LINES - b*32) > 32) ? 32 : (NUM_LINES - b*32);
    logic          sel;
    logic [BW-1:0] rd_w;

    assign sel = aligned && (int'(bank_idx) == b);

    eil_bank #(
      .W         (BW),
      .EN_MASK   (EN_MASKS[b*32 +: BW]),
      .TRIG_MASK (TRIG_MASKS[b*32 +: BW])
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we && sel),
      .reg_sel (reg_idx),
      .wdata   (bus_wdata[BW-1:0]),
      .rise    (rise_v[b*32 +: BW]),
      .fall    (fall_v[b*32 +: BW]),
      .rdata   (rd_w),
      .irq     (irq_pulse[b*32 +: BW])
    );

    always_comb begin
      rd_bank[b]         = '0;
      rd_bank[b][BW-1:0] = sel ? rd_w : '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NB; b++) bus_rdata = bus_rdata | rd_bank[b];
  end

endmodule

// File: tb/ext_line_ctrl_tb.sv
`timescale 1ns/1ps
module ext_line_ctrl_tb;
  localparam int NL = 40;

  logic          clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  wire  [31:0]   bus_rdata;
  logic [NL-1:0] line_in = '0;
  wire  [NL-1:0] irq_pulse;

  int vectors = 0, miscompares = 0;
  logic [31:0] m [2][8];
  int exp_irq [NL];
  int got_irq [NL];

  always #10 clk = ~clk;

  ext_line_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_in(line_in), .irq_pulse(irq_pulse)
  );

  always @(negedge clk)
    if (rst_n)
      for (int i = 0; i < NL; i++) if (irq_pulse[i]) got_irq[i]++;

  function automatic logic [31:0] en_mask(int b);
    return (b == 0) ? 32'hFFFF_FFFF : 32'h0000_00FF;
  endfunction
  function automatic logic [31:0] trig_mask(int b);
    return (b == 0) ? 32'h007D_FFFF : 32'h0000_0078;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_pend(int b, logic [31:0] bits);
    for (int k = 0; k < 32; k++)
      if (bits[k] && !m[b][5][k] && (b*32 + k < NL)) exp_irq[b*32 + k]++;
    m[b][5] = m[b][5] | bits;
  endtask

  task automatic model_write(int b, int r, logic [31:0] d);
    logic [31:0] nw, fire, c;
    case (r)
      0, 1: m[b][r] = d & en_mask(b);
      2, 3: m[b][r] = d & trig_mask(b);
      4: begin
        nw   = d & trig_mask(b);
        fire = nw & ~m[b][4] & m[b][0];
        m[b][4] = nw;
        set_pend(b, fire);
      end
      5: begin
        c = d & trig_mask(b);
        m[b][5] = m[b][5] & ~c;
        m[b][4] = m[b][4] & ~c;
      end
      default: ;
    endcase
  endtask

  task automatic wr(int b, int r, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'(b*32 + r*4); bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
    model_write(b, r, d);
  endtask

  task automatic rd(int b, int r, string req);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'(b*32 + r*4);
    #2;
    check(req, $sformatf("bank%0d reg%0d", b, r), bus_rdata, m[b][r]);
  endtask

  task automatic toggle(int l);
    int b, k;
    logic sel;
    b = l / 32; k = l % 32;
    @(negedge clk);
    line_in[l] = ~line_in[l];
    repeat (3) @(posedge clk);
    sel = line_in[l] ? m[b][2][k] : m[b][3][k];
    if (m[b][0][k] && sel && trig_mask(b)[k]) set_pend(b, 32'(1) << k);
  endtask

  task automatic chk_irq(string req);
    int bad, first;
    bad = 0; first = 0;
    @(negedge clk); #2;
    for (int i = 0; i < NL; i++)
      if (exp_irq[i] != got_irq[i]) begin
        if (bad == 0) first = i;
        bad++;
      end
    vectors++;
    if (bad != 0) begin
      miscompares++;
      $display("FAIL %s pulse count line %0d: got %0d expected %0d",
               req, first, got_irq[first], exp_irq[first]);
    end
  endtask

  task automatic check_all(string req);
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 6; r++) rd(b, r, req);
    chk_irq(req);
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int r = 0; r < 8; r++) m[b][r] = '0;
    for (int i = 0; i < NL; i++) begin exp_irq[i] = 0; got_irq[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    check_all("R1");
    check("R1", "irq after reset", 32'(irq_pulse), 32'h0);

    // R2: enable registers, per-bank width
    wr(0, 0, 32'hFFFF_FFFF); rd(0, 0, "R2");
    wr(1, 0, 32'hFFFF_FFFF); rd(1, 0, "R2");
    wr(0, 1, 32'hFFFF_FFFF); rd(0, 1, "R2");
    wr(1, 1, 32'hFFFF_FF00); rd(1, 1, "R2");
    wr(0, 0, 0); wr(1, 0, 0); wr(0, 1, 0); wr(1, 1, 0);
    rd(1, 0, "R2");

    // R3: edge select masks
    wr(0, 2, 32'hFFFF_FFFF); rd(0, 2, "R3");
    wr(1, 3, 32'hFFFF_FFFF); rd(1, 3, "R3");
    wr(0, 2, 0); wr(1, 3, 0);

    // R4: direct lines in software trigger and pending
    wr(0, 4, 32'hFF82_0000); rd(0, 4, "R4");
    wr(0, 5, 32'hFF82_0000); rd(0, 5, "R4");
    wr(1, 4, 32'h0000_0087); rd(1, 4, "R4");
    wr(1, 4, 32'hFFFF_FF00); rd(1, 4, "R4");
    wr(0, 0, 32'hFFFF_FFFF); wr(0, 2, 32'hFFFF_FFFF);
    toggle(17); rd(0, 5, "R4");
    wr(0, 0, 0); wr(0, 2, 0);

    // R5: software trigger on enabled line
    wr(0, 0, 32'h1); wr(0, 4, 32'h0);
    wr(0, 4, 32'h1);
    check("R5", "irq at capturing edge", 32'(irq_pulse[0]), 32'h1);
    @(posedge clk); #1;
    check("R10", "irq one cycle only", 32'(irq_pulse[0]), 32'h0);
    rd(0, 4, "R5"); rd(0, 5, "R5");
    // R10: no pulse for an already pending line
    wr(0, 4, 32'h0); wr(0, 4, 32'h1);
    chk_irq("R10");
    // R7: write 0 no effect, write 1 clears both
    wr(0, 5, 32'h0); rd(0, 5, "R7");
    wr(0, 5, 32'h1); rd(0, 5, "R7"); rd(0, 4, "R7");
    wr(1, 0, 32'h8); wr(1, 4, 32'h0); wr(1, 4, 32'h8);
    rd(1, 4, "R5"); rd(1, 5, "R5");
    wr(1, 5, 32'h8); rd(1, 5, "R7"); rd(1, 4, "R7");

    // R6: software trigger while disabled
    wr(0, 0, 0); wr(0, 4, 0); wr(0, 4, 32'h1);
    rd(0, 4, "R6"); rd(0, 5, "R6");
    wr(0, 0, 32'h1); rd(0, 5, "R6");
    wr(0, 4, 0); wr(0, 0, 0);

    // R8: hardware edges, timing and polarity
    wr(0, 0, 32'h2); wr(0, 2, 32'h2); wr(0, 3, 32'h0);
    @(negedge clk) line_in[1] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R8", "no irq at second edge", 32'(irq_pulse[1]), 32'h0);
    @(posedge clk); #1;
    check("R8", "irq at third edge", 32'(irq_pulse[1]), 32'h1);
    set_pend(0, 32'h2);
    rd(0, 5, "R8");
    wr(0, 5, 32'h2); toggle(1); rd(0, 5, "R8");
    wr(0, 2, 0); wr(0, 3, 32'h2);
    toggle(1); rd(0, 5, "R8");
    toggle(1); rd(0, 5, "R8"); wr(0, 5, 32'h2);
    wr(0, 2, 32'h2);
    toggle(1); rd(0, 5, "R8"); wr(0, 5, 32'h2);
    toggle(1); rd(0, 5, "R8"); wr(0, 5, 32'h2);
    wr(0, 2, 0); wr(0, 3, 0);
    toggle(1); rd(0, 5, "R8");
    toggle(1); rd(0, 5, "R8");

    // R9: edge while disabled is lost
    wr(0, 0, 0); wr(0, 2, 32'h4);
    toggle(2); rd(0, 5, "R9");
    wr(0, 0, 32'h4); rd(0, 5, "R9");
    wr(0, 2, 0); toggle(2);

    // R11: hardware set and clear on the same edge
    wr(0, 0, 32'h2); wr(0, 2, 32'h2); wr(0, 3, 32'h2);
    wr(0, 4, 0); wr(0, 4, 32'h2);
    @(negedge clk) line_in[1] = ~line_in[1];
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h2;
    @(posedge clk); #1;
    bus_we = 1'b0;
    m[0][4] = m[0][4] & ~32'h2;
    rd(0, 5, "R11"); rd(0, 4, "R11");
    wr(0, 5, 32'h2); wr(0, 2, 0); wr(0, 3, 0); wr(0, 0, 0);
    chk_irq("R10");

    // R12: unmapped addresses
    @(negedge clk); bus_addr = 8'h18; #2;
    check("R12", "index 6 read", bus_rdata, 32'h0);
    @(negedge clk); bus_addr = 8'h40; #2;
    check("R12", "bank 2 read", bus_rdata, 32'h0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h01; bus_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    bus_we = 1'b0;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h40; bus_wdata = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    bus_we = 1'b0;
    rd(0, 0, "R12");

    // Random mix of writes and input changes (R2..R10)
    void'($urandom(32'd20240611));
    for (int it = 0; it < 400; it++) begin
      int op, b, r;
      logic [31:0] d;
      op = $urandom % 4;
      if (op == 0) toggle($urandom % NL);
      else begin
        b = $urandom % 2;
        r = $urandom % 8;
        d = ($urandom % 2 == 0) ? $urandom : (32'(1) << ($urandom % 32));
        wr(b, r, d);
      end
      if (it % 8 == 7) check_all("R5/R7/R8 random");
    end
    check_all("R10 final");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule